// File: doc/BRIEF.md
# Data-Rate Prescaler and Scaled Timeout Timer

This block sets the bit rate of a token-passing network controller and times its protocol timeouts. A single fast clock stands in for the quadrupled reference. A two-bit multiplier code picks an internal clock of one, two or four times the base rate, and a three-bit prescaler code picks a divide ratio of 8 to 128. Together they set the bit period, in fast-clock cycles, of a one-cycle bit strobe. The bit period is always a power of two.

Each protocol timeout holds a fixed count of bit times, for example 205 bit times for the idle-line timeout. Its counter steps only on the bit strobe. A slower rate therefore stretches every timeout by the same power-of-two factor, and one table of counts serves every rate. The block reports the base-2 logarithm of that factor, from 0 at the fastest rate to 6 at the slowest.

A new rate request takes effect only when every timeout counter is idle. When it does, the divider restarts from phase zero, so no shortened bit period follows the change.

Top module: `rate_tmo_gen`

## Requirements
- R1: Multiplier code 2'b00 selects x1, 2'b01 selects x2 and 2'b10 selects x4. The bit strobe period is P = 2^(3 + d + 2 - m) fast-clock cycles, where m is 0, 1 or 2 for x1, x2 or x4 and d is the effective prescaler code.
- R2: Prescaler codes 0 to 4 divide by 8, 16, 32, 64 and 128 (d = code). Codes 5, 6 and 7 behave as code 4.
- R3: The reserved multiplier code 2'b11 behaves exactly as 2'b00 (x1).
- R4: `scale_exp_o` equals log2(P) - 3 for the active rate. Its range is 0 (x4, code 0) to 6 (x1, code 4).
- R5: `bit_stb_o` is high for exactly one cycle in every P cycles.
- R6: A start pulse on timer i loads its base count N_i. `tmo_expired_o[i]` is high for exactly one cycle, in the cycle right after the N_i-th cycle after the start cycle in which `bit_stb_o` was high.
- R7: `tmo_busy_o[i]` is high from the cycle after a start until the expiry cycle, and is low in the expiry cycle.
- R8: A start on a running timer reloads N_i. A bit strobe in the same cycle as a start is not counted.
- R9: A changed rate request is applied only at a clock edge where no timer is busy. Until then the old rate, and its `scale_exp_o`, stay in force.
- R10: When a rate is applied, the divider restarts. The new `scale_exp_o` shows in the cycle after the applying edge, counted as cycle 1, and the first strobe at the new rate is in cycle P.
- R11: During reset, the active rate is x1 with code 0 (`scale_exp_o` = 2). No strobe is issued and every busy and expired output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (quadrupled-reference rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| mul_sel_i | input | 2 | Requested clock multiplier code |
| pre_sel_i | input | 3 | Requested prescaler code |
| tmo_start_i | input | NUM_TMO | Per-timer start / restart pulse |
| bit_stb_o | output | 1 | One-cycle bit-rate strobe |
| scale_exp_o | output | EXP_W | log2 of the timeout stretch factor of the active rate |
| tmo_busy_o | output | NUM_TMO | Timer is counting |
| tmo_expired_o | output | NUM_TMO | One-cycle timer expiry pulse |

## Verification
A rate change shows on `scale_exp_o` one cycle after the edge that applies it. The first strobe at the new rate follows P cycles after that edge, and each later strobe P cycles after the one before. The bench therefore counts cycles from the first negative edge at which the new exponent is visible, and then from strobe to strobe. Expiry is due one cycle after the N-th counted strobe, so the bench counts strobes seen at negative edges after the start cycle and checks that the strobe was high in the cycle just before the expiry. Rate deferral is checked by sampling the exponent in the expiry cycle, where it must still hold the old value, and in the cycle after, where it must hold the new one.

// File: rtl/rtmo_pkg.sv
package rtmo_pkg;

   localparam int MUL_W       = 2;
   localparam int PRE_W       = 3;
   localparam int MUL_LOG_MAX = 2;

   typedef enum logic [MUL_W-1:0] {
      MUL_X1  = 2'b00,
      MUL_X2  = 2'b01,
      MUL_X4  = 2'b10,
      MUL_RSV = 2'b11
   } mul_sel_e;

   typedef struct packed {
      mul_sel_e           mul;
      logic [PRE_W-1:0]   pre;
   } rate_cfg_t;

   localparam rate_cfg_t RATE_RST = '{mul: MUL_X1, pre: '0};

   // log2 of the clock multiplier; undefined codes act as x1
   function automatic int mul_log(mul_sel_e m);
      case (m)
         MUL_X2:  return 1;
         MUL_X4:  return 2;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/rtmo_rate_decode.sv
module rtmo_rate_decode
   import rtmo_pkg::*;
#(
   parameter int PRE_STEPS    = 5,
   parameter int DIV_BASE_LOG = 3,
   parameter int EXP_W        = 3,
   parameter int LOG_W        = 4
) (
   input  rate_cfg_t          cfg,
   output logic [EXP_W-1:0]   scale_exp,
   output logic [LOG_W-1:0]   period_log
);

   if (PRE_STEPS < 1 || PRE_STEPS > (1 << PRE_W)) begin : g_bad_steps
      $error("rtmo_rate_decode: PRE_STEPS out of range");
   end

   logic [PRE_W-1:0] pre_eff;

   // codes beyond the last prescaler step saturate at the slowest step
   if (PRE_STEPS < (1 << PRE_W)) begin : g_clamp
      always_comb begin
         if (cfg.pre > PRE_W'(PRE_STEPS - 1))
            pre_eff = PRE_W'(PRE_STEPS - 1);
         else
            pre_eff = cfg.pre;
      end
   end else begin : g_direct
      assign pre_eff = cfg.pre;
   end

   always_comb begin
      scale_exp  = EXP_W'(pre_eff) + EXP_W'(MUL_LOG_MAX - mul_log(cfg.mul));
      period_log = LOG_W'(scale_exp) + LOG_W'(DIV_BASE_LOG);
   end

endmodule

// File: rtl/rtmo_rate_ctrl.sv
module rtmo_rate_ctrl
   import rtmo_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  rate_cfg_t req,
   input  logic      any_busy,
   output rate_cfg_t active,
   output logic      apply
);

   rate_cfg_t req_n;

   // fold the reserved multiplier code onto x1 so it never forces a phase reset
   always_comb begin
      req_n = req;
      if (req.mul == MUL_RSV)
         req_n.mul = MUL_X1;
   end

   assign apply = (req_n != active) && !any_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         active <= RATE_RST;
      else if (apply)
         active <= req_n;
   end

endmodule

// File: rtl/rtmo_bit_div.sv
module rtmo_bit_div #(
   parameter int DIV_W = 9,
   parameter int LOG_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [LOG_W-1:0] period_log,
   output logic             bit_stb
);

   if (DIV_W < 1 || DIV_W >= (1 << LOG_W)) begin : g_bad_w
      $error("rtmo_bit_div: DIV_W does not fit LOG_W");
   end

   logic [DIV_W-1:0] phase;
   logic [DIV_W-1:0] term;

   // terminal count is 2^period_log - 1, built as a mask of low ones
   assign term    = ~({DIV_W{1'b1}} << period_log);
   assign bit_stb = (phase == term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase <= '0;
      else if (restart || bit_stb)
         phase <= '0;
      else
         phase <= phase + DIV_W'(1);
   end

endmodule

// File: rtl/rtmo_tmo_cnt.sv
module rtmo_tmo_cnt #(
   parameter int          CNT_W = 16,
   parameter int unsigned BASE  = 205
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic tick,
   output logic busy,
   output logic expired
);

   logic [CNT_W-1:0] remain;

   assign busy = (remain != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain  <= '0;
         expired <= 1'b0;
      end else begin
         expired <= 1'b0;
         if (start) begin
            remain <= CNT_W'(BASE);
         end else if (tick && busy) begin
            remain <= remain - CNT_W'(1);
            if (remain == CNT_W'(1))
               expired <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/rate_tmo_gen.sv
module rate_tmo_gen
   import rtmo_pkg::*;
#(
   parameter int          NUM_TMO               = 3,
   parameter int          CNT_W                 = 16,
   parameter int unsigned TMO_BASE [NUM_TMO]    = '{205, 41, 9},
   parameter int          DIV_BASE_LOG          = 3,
   parameter int          PRE_STEPS             = 5
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [MUL_W-1:0]            mul_sel_i,
   input  logic [PRE_W-1:0]            pre_sel_i,
   input  logic [NUM_TMO-1:0]          tmo_start_i,
   output logic                        bit_stb_o,
   output logic [((PRE_STEPS - 1 + MUL_LOG_MAX) < 1 ? 1 :
                  $clog2(PRE_STEPS + MUL_LOG_MAX)) - 1:0] scale_exp_o,
   output logic [NUM_TMO-1:0]          tmo_busy_o,
   output logic [NUM_TMO-1:0]          tmo_expired_o
);

   localparam int MAX_EXP = PRE_STEPS - 1 + MUL_LOG_MAX;
   localparam int MAX_LOG = MAX_EXP + DIV_BASE_LOG;
   localparam int EXP_W   = (MAX_EXP < 1) ? 1 : $clog2(MAX_EXP + 1);
   localparam int LOG_W   = $clog2(MAX_LOG + 1);
   localparam int DIV_W   = MAX_LOG;

   if (NUM_TMO < 1) begin : g_bad_num
      $error("rate_tmo_gen: NUM_TMO must be at least 1");
   end
   if (DIV_BASE_LOG < 1) begin : g_bad_base
      $error("rate_tmo_gen: DIV_BASE_LOG must be at least 1");
   end

   rate_cfg_t        req_cfg;
   rate_cfg_t        act_cfg;
   logic             rate_apply;
   logic [LOG_W-1:0] period_log;

   assign req_cfg = '{mul: mul_sel_e'(mul_sel_i), pre: pre_sel_i};

   rtmo_rate_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req_cfg),
      .any_busy (|tmo_busy_o),
      .active   (act_cfg),
      .apply    (rate_apply)
   );

   rtmo_rate_decode #(
      .PRE_STEPS    (PRE_STEPS),
      .DIV_BASE_LOG (DIV_BASE_LOG),
      .EXP_W        (EXP_W),
      .LOG_W        (LOG_W)
   ) u_dec (
      .cfg        (act_cfg),
      .scale_exp  (scale_exp_o),
      .period_log (period_log)
   );

   rtmo_bit_div #(
      .DIV_W (DIV_W),
      .LOG_W (LOG_W)
   ) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (rate_apply),
      .period_log (period_log),
      .bit_stb    (bit_stb_o)
   );

   for (genvar g = 0; g < NUM_TMO; g++) begin : g_tmo
      if (TMO_BASE[g] < 1 || 64'(TMO_BASE[g]) >= (64'd1 << CNT_W)) begin : g_bad_cnt
         $error("rate_tmo_gen: timeout base count does not fit CNT_W");
      end
      rtmo_tmo_cnt #(
         .CNT_W (CNT_W),
         .BASE  (TMO_BASE[g])
      ) u_cnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .start   (tmo_start_i[g]),
         .tick    (bit_stb_o),
         .busy    (tmo_busy_o[g]),
         .expired (tmo_expired_o[g])
      );
   end

endmodule

// File: rtl/rate_tmo_gen_chk.sv
module rate_tmo_gen_chk #(
   parameter int NUM_TMO = 3,
   parameter int EXP_W   = 3,
   parameter int MAX_EXP = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bit_stb,
   input logic [EXP_W-1:0]   scale_exp,
   input logic [NUM_TMO-1:0] busy,
   input logic [NUM_TMO-1:0] expired,
   input logic [NUM_TMO-1:0] start
);

   a_r5_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
      bit_stb |=> !bit_stb);

   a_r4_exp_range: assert property (@(posedge clk) disable iff (!rst_n)
      scale_exp <= EXP_W'(MAX_EXP));

   a_r9_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (|busy) |=> $stable(scale_exp));

   a_r10_no_runt: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(scale_exp) |-> !bit_stb);

   for (genvar g = 0; g < NUM_TMO; g++) begin : g_chk
      a_r6_exp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
         expired[g] |=> !expired[g]);

      a_r6_exp_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
         expired[g] |-> $past(bit_stb));

      a_r7_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(busy[g]) |-> expired[g]);

      a_r8_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
         start[g] |=> (busy[g] && !expired[g]));
   end

endmodule

bind rate_tmo_gen rate_tmo_gen_chk #(
   .NUM_TMO (NUM_TMO),
   .EXP_W   (EXP_W),
   .MAX_EXP (MAX_EXP)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bit_stb   (bit_stb_o),
   .scale_exp (scale_exp_o),
   .busy      (tmo_busy_o),
   .expired   (tmo_expired_o),
   .start     (tmo_start_i)
);

// File: tb/test_rate_tmo_gen.sv
module test_rate_tmo_gen;

   localparam int NT    = 3;
   localparam int LIMIT = 40000;
   localparam int NVEC  = 9;
   // {multiplier code, prescaler code, expected log2 of bit period}
   localparam int VEC [NVEC][3] = '{
      '{2, 0, 3}, '{0, 4, 9}, '{1, 0, 4}, '{0, 7, 9}, '{3, 0, 5},
      '{0, 2, 7}, '{0, 1, 6}, '{2, 4, 7}, '{0, 3, 8}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    mul = 2'd0;
   logic [2:0]    pre = 3'd0;
   logic [NT-1:0] tmo_start = '0;
   logic          bit_stb;
   logic [2:0]    scale_exp;
   logic [NT-1:0] tmo_busy;
   logic [NT-1:0] tmo_expired;

   int n_run = 0;
   int n_fail = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   rate_tmo_gen #(
      .NUM_TMO  (NT),
      .CNT_W    (8),
      .TMO_BASE ('{6, 3, 1})
   ) i_rate_tmo_gen (
      .clk           (clk),
      .rst_n         (rst_n),
      .mul_sel_i     (mul),
      .pre_sel_i     (pre),
      .tmo_start_i   (tmo_start),
      .bit_stb_o     (bit_stb),
      .scale_exp_o   (scale_exp),
      .tmo_busy_o    (tmo_busy),
      .tmo_expired_o (tmo_expired)
   );

   task automatic check(string tag, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc >= LIMIT) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, LIMIT);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   // request a rate, then time the first strobe and one full period
   task automatic set_rate(int m, int p, int lg, string tag);
      int prev = int'(scale_exp);
      int n;
      mul = 2'(m);
      pre = 3'(p);
      do @(negedge clk); while (int'(scale_exp) == prev);
      check("R4 exponent", int'(scale_exp), lg - 3);
      n = 1;
      while (!bit_stb) begin
         @(negedge clk);
         n++;
      end
      check("R10 first strobe after apply", n, 1 << lg);
      @(negedge clk);
      check("R5 strobe one cycle", int'(bit_stb), 0);
      n = 1;
      while (!bit_stb) begin
         @(negedge clk);
         n++;
      end
      check(tag, n, 1 << lg);
   endtask

   task automatic run_tmo(int idx, int nb, string tag);
      int  strobes = 0;
      int  last = 0;
      int  busy_ok = 1;
      tmo_start[idx] = 1'b1;
      forever begin
         @(negedge clk);
         tmo_start[idx] = 1'b0;
         if (tmo_expired[idx]) break;
         if (!tmo_busy[idx]) busy_ok = 0;
         if (bit_stb) strobes++;
         last = int'(bit_stb);
      end
      check(tag, strobes, nb);
      check("R6 strobe just before expiry", last, 1);
      check("R7 busy while counting", busy_ok, 1);
      check("R7 busy low at expiry", int'(tmo_busy[idx]), 0);
      @(negedge clk);
      check("R6 expiry is one cycle", int'(tmo_expired[idx]), 0);
   endtask

   initial begin
      int early;
      int cnt;
      int bad;

      // reset state
      repeat (3) @(negedge clk);
      check("R11 exponent in reset", int'(scale_exp), 2);
      check("R11 no strobe in reset", int'(bit_stb), 0);
      check("R11 busy low in reset", int'(tmo_busy), 0);
      check("R11 expired low in reset", int'(tmo_expired), 0);
      rst_n = 1'b1;

      // rate table
      for (int v = 0; v < NVEC; v++) begin
         string tag;
         if (VEC[v][0] == 3)      tag = "R3 reserved multiplier period";
         else if (VEC[v][1] > 4)  tag = "R2 saturated prescaler period";
         else                     tag = "R1 bit period";
         set_rate(VEC[v][0], VEC[v][1], VEC[v][2], tag);
      end

      // timeouts at the fastest rate
      set_rate(2, 0, 3, "R1 bit period x4 code 0");
      run_tmo(0, 6, "R6 strobes to expiry timer0");
      run_tmo(2, 1, "R6 strobes to expiry single count");

      // restart of a running timer, coinciding with a strobe
      early = 0;
      cnt = 0;
      tmo_start[1] = 1'b1;
      while (cnt < 2) begin
         @(negedge clk);
         tmo_start[1] = 1'b0;
         if (tmo_expired[1]) early = 1;
         if (bit_stb) cnt++;
      end
      check("R8 no expiry before restart", early, 0);
      run_tmo(1, 3, "R8 restart reloads and skips coincident strobe");

      // rate request held back while a timer runs
      tmo_start[0] = 1'b1;
      @(negedge clk);
      tmo_start[0] = 1'b0;
      mul = 2'd0;
      pre = 3'd0;
      bad = 0;
      while (!tmo_expired[0]) begin
         if (scale_exp != 3'd0) bad++;
         @(negedge clk);
      end
      check("R9 rate held while busy", bad, 0);
      check("R9 old exponent in expiry cycle", int'(scale_exp), 0);
      @(negedge clk);
      check("R9 new exponent after expiry", int'(scale_exp), 2);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule